// File: doc/BRIEF.md
# Multi-Block Erase Scheduler with Block Protection

This block sequences erase work for a 1 MB byte-wide flash array that is divided into 19 blocks of unequal size. The command decoder hands it single-cycle requests. A block-erase request carries the top seven address bits (byte address bits 19 down to 13). The scheduler maps those bits to a block index and adds the block to a pending set. Each new request reopens an acceptance window, and erasure starts only once the window has run out with no further request. A chip-erase request selects every block at once and starts immediately.

Protected blocks are left out of the set. While the temporary-unprotect input is held, the stored protect bits are disregarded. Pending blocks are erased one at a time, lowest index first, and each block takes a programmable number of clock cycles. An erase in progress can be suspended and later resumed. When no block could be selected, the scheduler stays busy for a fixed interval and then returns to idle without erasing anything.

The block map depends on a strap. In the top-boot layout the 16 KB boot block is at the top of the address space. In the bottom-boot layout it is at the bottom, and the two 8 KB blocks and the 32 KB block sit next to it.

Top module: `erase_sched`

## Requirements
- R1: With `boot_top`=1 and seven address bits `a` (byte address a·8192), addresses below 0xF0000 map to index addr>>16. The range 0xF0000–0xF7FFF (32 KB) maps to 15, 0xF8000–0xF9FFF to 16, 0xFA000–0xFBFFF to 17, and 0xFC000–0xFFFFF (16 KB boot block) to 18.
- R2: With `boot_top`=0, the range 0x00000–0x03FFF (boot block) maps to 0, 0x04000–0x05FFF to 1, 0x06000–0x07FFF to 2, and 0x08000–0x0FFFF to 3. Every address from 0x10000 upward maps to (addr>>16)+3.
- R3: Each accepted block-erase request holds `window_open` high and reloads the acceptance window to ACC_CYC cycles. Erasure starts only after ACC_CYC cycles pass with no further request.
- R4: A block whose `prot_mask` bit is 1 is never added to `pending` and never erased, unless `temp_unprot` is 1 when the request arrives.
- R5: If the selection is empty when erasure would start, `all_prot` is high for HOLD_CYC cycles and `ready` is low for that time. No block is erased, and the block then returns to idle.
- R6: Pending blocks are erased in ascending index order. Each block keeps `erase_active` high with `cur_blk` equal to its index for `erase_cycles` cycles.
- R7: `ready` is 0 during the acceptance window, the erase and the all-protected hold. It is 1 when idle or suspended. `busy` is 1 whenever the block is not idle.
- R8: `suspend_req` during an erase freezes the work: `suspended`=1 and `ready`=1, while `pending` and `cur_blk` are kept. `resume_req` restarts the interrupted block with its full erase time.
- R9: `chip_erase_req` from idle selects every unprotected block and starts erasing the next cycle, with no acceptance window.
- R10: `rst_n` low aborts any operation. It returns the block to idle with `pending` cleared.
- R11: `done` pulses for one cycle, at the same time as `ready` rises, when the last pending block finishes erasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, aborts erase |
| boot_top | input | 1 | Strap: 1 = boot block at top, 0 = at bottom |
| blk_erase_req | input | 1 | Block-erase request pulse |
| blk_sel_addr | input | 7 | Byte address bits 19..13 of the block to erase |
| chip_erase_req | input | 1 | Chip-erase request pulse |
| suspend_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| prot_mask | input | 19 | Stored protect bit per block index |
| temp_unprot | input | 1 | Treat all blocks as unprotected while high |
| erase_cycles | input | CW | Erase time per block in cycles |
| ready | output | 1 | Ready/busy level, high when idle or suspended |
| busy | output | 1 | Scheduler not idle |
| window_open | output | 1 | Acceptance window running |
| erase_active | output | 1 | A block is being erased |
| suspended | output | 1 | Erase suspended |
| all_prot | output | 1 | Empty-selection hold in progress |
| cur_blk | output | 5 | Index of block being (or last) erased |
| pending | output | 19 | Blocks still to erase |
| done | output | 1 | One-cycle pulse at end of a completed erase |

## Verification
The bench sweeps every address code under both strap settings. It compares the erased index with a map that it derives from byte-address ranges, so a map that misplaces the 8 KB or 32 KB blocks, or that mirrors the layout wrongly, shows up as a wrong index. It times ready-low intervals exactly. A window that is not reopened by a late request, or an erase time that is off by one, changes the measured length. It also mixes protect bits with the temporary-unprotect input, and a design that ignored protection or the override would erase too many or too few blocks. Suspend and resume are checked mid-block, so a design that dropped the interrupted block or skipped to the next one would give a short total time.

// File: rtl/esched_pkg.sv
package esched_pkg;
  localparam int NBLK = 19;
  localparam int IW   = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_ACC, S_HOLD, S_ERASE, S_SUSP
  } esch_st_e;

  // block index from address bits 19..13, bit-field decode
  function automatic logic [IW-1:0] blk_of(input logic top, input logic [6:0] a);
    logic [3:0] hi;
    logic [IW-1:0] r;
    hi = a[6:3];
    if (top) begin
      if (hi != 4'hF) r = {1'b0, hi};
      else begin
        case (a[2:0])
          3'd4:    r = 5'd16;
          3'd5:    r = 5'd17;
          3'd6,
          3'd7:    r = 5'd18;
          default: r = 5'd15;
        endcase
      end
    end else begin
      if (hi != 4'h0) r = {1'b0, hi} + 5'd3;
      else begin
        case (a[2:0])
          3'd0, 3'd1: r = 5'd0;
          3'd2:       r = 5'd1;
          3'd3:       r = 5'd2;
          default:    r = 5'd3;
        endcase
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/esched_map.sv
module esched_map
  import esched_pkg::*;
(
  input  logic          boot_top,
  input  logic [6:0]    addr_hi,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = blk_of(boot_top, addr_hi);
    // R1 R2
    map_range_chk: assert (idx < IW'(NBLK));
  end
endmodule

// File: rtl/esched_timer.sv
module esched_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R6
  tmr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/esched_pick.sv
module esched_pick
  import esched_pkg::*;
#(
  parameter int NB = NBLK
) (
  input  logic [NB-1:0] req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  logic [NB-1:0] oh;

  for (genvar g = 0; g < NB; g++) begin : g_low
    if (g == 0) begin : g_first
      assign oh[g] = req[g];
    end else begin : g_rest
      assign oh[g] = req[g] & ~(|req[g-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NB; i++)
      if (oh[i]) idx = idx | IW'(i);
  end

  assign vld = |req;

  always_comb begin
    // R6
    pick_onehot_chk: assert ($onehot0(oh));
  end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import esched_pkg::*;
#(
  parameter int CW       = 16,
  parameter int ACC_CYC  = 64,
  parameter int HOLD_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_top,
  input  logic          blk_erase_req,
  input  logic [6:0]    blk_sel_addr,
  input  logic          chip_erase_req,
  input  logic          suspend_req,
  input  logic          resume_req,
  input  logic [18:0]   prot_mask,
  input  logic          temp_unprot,
  input  logic [CW-1:0] erase_cycles,
  output logic          ready,
  output logic          busy,
  output logic          window_open,
  output logic          erase_active,
  output logic          suspended,
  output logic          all_prot,
  output logic [4:0]    cur_blk,
  output logic [18:0]   pending,
  output logic          done
);
  localparam logic [CW-1:0] ACC_LD  = CW'(ACC_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);

  esch_st_e        st_q, st_n;
  logic [NBLK-1:0] pend_q, pend_n;
  logic [IW-1:0]   cur_q, cur_n;
  logic            done_q, done_n;

  logic [NBLK-1:0] eff_prot, req_bit, add_mask, cur_bit, rem, pick_in;
  logic [IW-1:0]   map_idx, pick_idx;
  logic            pick_vld, t_exp, t_load;
  logic [CW-1:0]   t_val, ec_ld;

  // internal events brought out as named wires
  assign eff_prot = temp_unprot ? '0 : prot_mask;
  assign req_bit  = NBLK'(1) << map_idx;
  assign add_mask = req_bit & ~eff_prot;
  assign cur_bit  = NBLK'(1) << cur_q;
  assign rem      = pend_q & ~cur_bit;
  assign ec_ld    = (erase_cycles == '0) ? '0 : erase_cycles - 1'b1;

  always_comb begin
    case (st_q)
      S_IDLE:  pick_in = ~eff_prot;
      S_ERASE: pick_in = rem;
      default: pick_in = pend_q;
    endcase
  end

  esched_map u_map (
    .boot_top (boot_top),
    .addr_hi  (blk_sel_addr),
    .idx      (map_idx)
  );

  esched_pick #(.NB(NBLK)) u_pick (
    .req (pick_in),
    .vld (pick_vld),
    .idx (pick_idx)
  );

  esched_timer #(.TW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  always_comb begin
    st_n   = st_q;
    pend_n = pend_q;
    cur_n  = cur_q;
    t_load = 1'b0;
    t_val  = '0;
    done_n = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (chip_erase_req) begin
          pend_n = ~eff_prot;
          t_load = 1'b1;
          if (pick_vld) begin
            st_n  = S_ERASE;
            cur_n = pick_idx;
            t_val = ec_ld;
          end else begin
            st_n  = S_HOLD;
            t_val = HOLD_LD;
          end
        end else if (blk_erase_req) begin
          pend_n = add_mask;
          st_n   = S_ACC;
          t_load = 1'b1;
          t_val  = ACC_LD;
        end
      end
      S_ACC: begin
        if (blk_erase_req) begin
          pend_n = pend_q | add_mask;
          t_load = 1'b1;
          t_val  = ACC_LD;
        end else if (t_exp) begin
          t_load = 1'b1;
          if (pick_vld) begin
            st_n  = S_ERASE;
            cur_n = pick_idx;
            t_val = ec_ld;
          end else begin
            st_n  = S_HOLD;
            t_val = HOLD_LD;
          end
        end
      end
      S_HOLD: begin
        if (t_exp) begin
          st_n   = S_IDLE;
          pend_n = '0;
        end
      end
      S_ERASE: begin
        if (suspend_req) begin
          st_n = S_SUSP;
        end else if (t_exp) begin
          pend_n = rem;
          if (pick_vld) begin
            cur_n  = pick_idx;
            t_load = 1'b1;
            t_val  = ec_ld;
          end else begin
            st_n   = S_IDLE;
            done_n = 1'b1;
          end
        end
      end
      S_SUSP: begin
        if (resume_req) begin
          st_n   = S_ERASE;
          t_load = 1'b1;
          t_val  = ec_ld;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      cur_q  <= cur_n;
      done_q <= done_n;
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign ready        = (st_q == S_IDLE) || (st_q == S_SUSP);
  assign window_open  = (st_q == S_ACC);
  assign erase_active = (st_q == S_ERASE);
  assign suspended    = (st_q == S_SUSP);
  assign all_prot     = (st_q == S_HOLD);
  assign cur_blk      = cur_q;
  assign pending      = pend_q;
  assign done         = done_q;

  // R4
  no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_active |=> ((pending & ~$past(pending)) == '0));
  // R7
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (ready && busy));
  // R5
  hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_prot |-> (pending == '0));
  // R6
  cur_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_active |-> pending[cur_blk]);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pending == '0 && !busy && $past(erase_active)));
  // R8
  susp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && $past(suspended)) |-> ($stable(pending) && $stable(cur_blk)));
endmodule

// File: tb/sim_erase_sched.sv
module sim_erase_sched;
  localparam int CW = 8, ACC = 4, HOLD = 6, E = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot_top = 1'b1, blk_erase_req = 1'b0, chip_erase_req = 1'b0;
  logic suspend_req = 1'b0, resume_req = 1'b0, temp_unprot = 1'b0;
  logic [6:0]  blk_sel_addr = '0;
  logic [18:0] prot_mask = '0;
  logic [CW-1:0] erase_cycles = CW'(E);
  logic ready, busy, window_open, erase_active, suspended, all_prot, done;
  logic [4:0] cur_blk;
  logic [18:0] pending;

  int tests = 0, fails = 0;
  int seq[0:31];
  int nseq, n;
  bit all_seen, done_exit, finished = 0;

  always #2 clk = ~clk;

  erase_sched #(.CW(CW), .ACC_CYC(ACC), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_top(boot_top),
    .blk_erase_req(blk_erase_req), .blk_sel_addr(blk_sel_addr),
    .chip_erase_req(chip_erase_req), .suspend_req(suspend_req),
    .resume_req(resume_req), .prot_mask(prot_mask), .temp_unprot(temp_unprot),
    .erase_cycles(erase_cycles), .ready(ready), .busy(busy),
    .window_open(window_open), .erase_active(erase_active),
    .suspended(suspended), .all_prot(all_prot), .cur_blk(cur_blk),
    .pending(pending), .done(done));

  function automatic int exp_blk(input bit top, input int a);
    int ad;
    ad = a * 8192;
    if (top) begin
      if (ad < 'hF0000) return ad / 65536;
      if (ad < 'hF8000) return 15;
      if (ad < 'hFA000) return 16;
      if (ad < 'hFC000) return 17;
      return 18;
    end
    if (ad < 'h04000) return 0;
    if (ad < 'h06000) return 1;
    if (ad < 'h08000) return 2;
    if (ad < 'h10000) return 3;
    return ad / 65536 + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic blk(input int a);
    @(negedge clk);
    blk_sel_addr = 7'(a);
    blk_erase_req = 1'b1;
    @(negedge clk);
    blk_erase_req = 1'b0;
  endtask

  task automatic pulse_chip();
    @(negedge clk); chip_erase_req = 1'b1;
    @(negedge clk); chip_erase_req = 1'b0;
  endtask

  // count ready-low cycles from the current negedge, logging erased blocks
  task automatic run_out();
    n = 0; nseq = 0; all_seen = 0;
    while (ready == 1'b0 && n < 2000) begin
      if (erase_active && (nseq == 0 || seq[nseq-1] != int'(cur_blk))) begin
        seq[nseq] = int'(cur_blk);
        nseq++;
      end
      if (all_prot) all_seen = 1;
      n++;
      @(negedge clk);
    end
    done_exit = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cnt_unp, k;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ready && !busy && pending == 0 && !done, "R10", int'(pending), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R6 R11: sweep every address under both straps
    for (int top = 0; top < 2; top++) begin
      boot_top = top[0];
      for (int a = 0; a < 128; a++) begin
        blk(a);
        run_out();
        chk(n == ACC + E, "R3", n, ACC + E);
        chk(nseq == 1 && seq[0] == exp_blk(top[0], a), top ? "R1" : "R2",
            seq[0], exp_blk(top[0], a));
        chk(done_exit, "R11", int'(done_exit), 1);
      end
    end

    // R7 levels during window
    boot_top = 1'b1;
    blk(5);
    chk(!ready && busy && window_open, "R7", int'(ready), 0);
    run_out();
    chk(ready && !busy, "R7", int'(busy), 0);

    // R3 window reload by a late request, R6 ascending order
    blk(40);                 // idx 5
    @(negedge clk);
    blk(8);                  // idx 1
    run_out();
    chk(n == ACC + 2 * E, "R3", n, ACC + 2 * E);
    chk(nseq == 2 && seq[0] == 1 && seq[1] == 5, "R6", seq[0], 1);

    // R4 protection and temporary unprotect
    prot_mask = 19'h00001;
    blk(0); blk(16);         // idx 0 protected, idx 2 free
    run_out();
    chk(n == ACC + E && nseq == 1 && seq[0] == 2, "R4", n, ACC + E);
    temp_unprot = 1'b1;
    blk(0); blk(16);
    run_out();
    chk(n == ACC + 2 * E && nseq == 2 && seq[0] == 0, "R4", n, ACC + 2 * E);
    temp_unprot = 1'b0;

    // R5 only protected blocks selected
    blk(0);
    run_out();
    chk(n == ACC + HOLD && all_seen && nseq == 0, "R5", n, ACC + HOLD);
    chk(!done_exit && pending == 0, "R5", int'(done_exit), 0);

    // R9 chip erase with a protect pattern
    prot_mask = 19'h2A5A5;
    cnt_unp = 0;
    for (int i = 0; i < 19; i++) if (!prot_mask[i]) cnt_unp++;
    pulse_chip();
    chk(erase_active && !window_open, "R9", int'(window_open), 0);
    run_out();
    chk(n == E * cnt_unp, "R9", n, E * cnt_unp);
    k = 0;
    for (int i = 0; i < 19; i++)
      if (!prot_mask[i]) begin
        chk(k < nseq && seq[k] == i, "R6", seq[k], i);
        k++;
      end
    // R5 chip erase with every block protected
    prot_mask = '1;
    pulse_chip();
    run_out();
    chk(n == HOLD && all_seen, "R5", n, HOLD);
    // R9 temp unprotect selects all 19
    temp_unprot = 1'b1;
    pulse_chip();
    run_out();
    chk(n == 19 * E && nseq == 19, "R9", n, 19 * E);
    temp_unprot = 1'b0;
    prot_mask = '0;

    // R8 suspend and resume
    blk(0); blk(8);          // idx 0, 1
    while (!erase_active) @(negedge clk);
    @(suspend_req or negedge clk);
    suspend_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0;
    chk(suspended && ready && busy, "R8", int'(ready), 1);
    chk(cur_blk == 0 && pending == 19'h3, "R8", int'(pending), 3);
    repeat (6) @(negedge clk);
    chk(suspended && ready && cur_blk == 0 && pending == 19'h3, "R8", int'(pending), 3);
    resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
    run_out();
    chk(n == 2 * E && nseq == 2 && seq[0] == 0 && seq[1] == 1, "R8", n, 2 * E);

    // R10 reset aborts
    pulse_chip();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(ready && !busy && pending == 0, "R10", int'(pending), 0);
    @(negedge clk);
    chk(ready && !erase_active, "R10", int'(erase_active), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule